// File: doc/BRIEF.md
# Single-Side Bypass Hazard Controller

This block decides, for the instruction in decode of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback), whether it may move on to execute and where its first ALU operand comes from. Only the first operand has bypass wires. It can take the execute/memory result, the memory/writeback result or the register-file value. The second operand can only be read from the register file. A dependency on that operand must therefore hold decode until the producer reaches writeback.

The register file is part of the block. It has two combinational read ports addressed by the decode source indices and one write port driven by writeback. A read of the register being written in the same cycle returns the incoming value. The select output is a decode-time decision: the pipeline carries it into execute with the instruction. While `stall` is high, the surrounding pipeline keeps its PC and fetch/decode register and loads a no-op, with every write enable cleared, into the decode/execute register. All pins are plain control and data levels, with no handshake. The decision depends only on the current inputs, and the next cycle re-evaluates it.

Top module: `partial_fwd_hazard_unit`

## Requirements
- R1: `src_a_sel` uses the code 0 for the register-file value, 1 for the execute/memory result and 2 for the memory/writeback result. The code 3 never appears.
- R2: When source A is used and equals the destination of a valid producer in execute, the select is 1, even if memory also matches.
- R3: When source A matches no valid execute producer but matches a valid producer in memory, the select is 2.
- R4: In all other cases the select is 0. This includes a match with writeback only, which the write-through covers.
- R5: A load in execute whose destination equals either used source raises `stall`, including source A.
- R6: When source B is used and equals the destination of a valid producer in execute or memory, `stall` is high. A match with writeback alone does not stall.
- R7: A producer is valid only if its write enable is high and its destination is not register 0. A source whose used flag is low or whose index is 0 creates no dependency.
- R8: When writeback writes register k (k ≠ 0) and a read port addresses k in the same cycle, that port returns `wb_data`.
- R9: After reset every register reads 0. A written value is held until it is overwritten. Register 0 always reads 0, and writes to it are dropped.
- R10: A non-load producer in execute or memory that matches only source A does not stall. A load in memory that matches source A gives select 2 with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the register file |
| dec_src_a | input | AW | Decode first source index (bypassable operand) |
| dec_src_a_used | input | 1 | Decode instruction reads source A |
| dec_src_b | input | AW | Decode second source index (no bypass) |
| dec_src_b_used | input | 1 | Decode instruction reads source B |
| ex_dst | input | AW | Destination of the instruction in execute |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_dst | input | AW | Destination of the instruction in memory |
| mem_wen | input | 1 | Memory instruction writes a register |
| wb_dst | input | AW | Writeback destination index |
| wb_wen | input | 1 | Writeback write enable |
| wb_data | input | DW | Writeback data |
| src_a_data | output | DW | Register-file value for source A |
| src_b_data | output | DW | Register-file value for source B |
| src_a_sel | output | 2 | Bypass select for operand A |
| stall | output | 1 | Hold fetch/decode and insert a bubble into execute |

## Verification
The bench goes after the places where the two operands behave differently. A hazard on source B in memory must stall, while the same hazard on source A must forward. A design that treats the operands alike would either lose cycles or read stale data. When execute and memory both match source A, the younger execute result must win. A reversed priority would deliver an out-of-date value. Register 0, cleared write enables and unused sources are aimed at a design that invents false dependencies. A load in execute matching source A checks a design that forwards data not yet loaded. Same-cycle write-through on both ports checks for a register file that returns the old value.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF = 2'd0,
    FWD_XM = 2'd1,
    FWD_MW = 2'd2
  } fwd_sel_e;
endpackage

// File: rtl/hz_dep_match.sv
// One source-versus-producer comparison; register 0 and idle producers never hit.
module hz_dep_match #(
  parameter int AW = 3
) (
  input  logic [AW-1:0] src,
  input  logic          src_used,
  input  logic [AW-1:0] dst,
  input  logic          dst_wen,
  output logic          hit
);
  always_comb begin
    hit = src_used && dst_wen && (dst != '0) && (src == dst);
  end
endmodule

// File: rtl/hz_regfile_wt.sv
// Register file with write-through on every read port.
module hz_regfile_wt #(
  parameter int NREG  = 8,
  parameter int DW    = 16,
  parameter int NRD   = 2,
  localparam int AW   = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NRD-1:0][AW-1:0] rd_addr,
  output logic [NRD-1:0][DW-1:0] rd_data,
  input  logic [AW-1:0]          wr_addr,
  input  logic                   wr_en,
  input  logic [DW-1:0]          wr_data
);
  logic [DW-1:0] regs [NREG];
  logic          wr_live;

  assign wr_live = wr_en && (wr_addr != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_live) begin
      regs[wr_addr] <= wr_data;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (rd_addr[p] == '0)
        rd_data[p] = '0;
      else if (wr_live && (wr_addr == rd_addr[p]))
        rd_data[p] = wr_data;
      else
        rd_data[p] = regs[rd_addr[p]];
    end

    // R8: same-cycle write returns the new value
    assert_write_through_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr != '0 && rd_addr[p] == wr_addr) |-> (rd_data[p] == wr_data));
    // R9: register 0 reads zero
    assert_zero_reg_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr[p] == '0) |-> (rd_data[p] == '0));
    // R9: an unwritten register keeps its value across a cycle
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && $stable(rd_addr[p])) |=> (!wr_en && $stable(rd_addr[p])) -> $stable(rd_data[p]));
  end
endmodule

// File: rtl/hz_fwd_sel.sv
// Priority bypass select for operand A: youngest producer wins.
module hz_fwd_sel (
  input  logic             hit_xm,
  input  logic             hit_mw,
  output hz_pkg::fwd_sel_e sel
);
  always_comb begin
    if (hit_xm)      sel = hz_pkg::FWD_XM;
    else if (hit_mw) sel = hz_pkg::FWD_MW;
    else             sel = hz_pkg::FWD_RF;
  end
endmodule

// File: rtl/hz_stall_gen.sv
// Decode hold: load-use on either source, or any in-flight producer of source B.
module hz_stall_gen (
  input  logic hit_a_ex,
  input  logic hit_b_ex,
  input  logic hit_b_mem,
  input  logic ex_load,
  output logic stall
);
  logic load_use;
  logic b_unbypassed;

  always_comb begin
    load_use     = ex_load && (hit_a_ex || hit_b_ex);
    b_unbypassed = hit_b_ex || hit_b_mem;
    stall        = load_use || b_unbypassed;
  end
endmodule

// File: rtl/partial_fwd_hazard_unit.sv
module partial_fwd_hazard_unit #(
  parameter int NREG = 8,
  parameter int DW   = 16,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] dec_src_a,
  input  logic          dec_src_a_used,
  input  logic [AW-1:0] dec_src_b,
  input  logic          dec_src_b_used,
  input  logic [AW-1:0] ex_dst,
  input  logic          ex_wen,
  input  logic          ex_load,
  input  logic [AW-1:0] mem_dst,
  input  logic          mem_wen,
  input  logic [AW-1:0] wb_dst,
  input  logic          wb_wen,
  input  logic [DW-1:0] wb_data,
  output logic [DW-1:0] src_a_data,
  output logic [DW-1:0] src_b_data,
  output logic [1:0]    src_a_sel,
  output logic          stall
);
  localparam int NSRC  = 2;
  localparam int NPROD = 2;  // execute, memory

  logic [NSRC-1:0][AW-1:0]  src_idx;
  logic [NSRC-1:0]          src_used;
  logic [NPROD-1:0][AW-1:0] prod_dst;
  logic [NPROD-1:0]         prod_wen;
  logic [NSRC-1:0][NPROD-1:0] hit;
  logic [NSRC-1:0][DW-1:0]  rd_data;
  hz_pkg::fwd_sel_e         sel_e;

  assign src_idx  = {dec_src_b, dec_src_a};
  assign src_used = {dec_src_b_used, dec_src_a_used};
  assign prod_dst = {mem_dst, ex_dst};
  assign prod_wen = {mem_wen, ex_wen};

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    for (genvar p = 0; p < NPROD; p++) begin : g_prod
      hz_dep_match #(.AW(AW)) u_match (
        .src     (src_idx[s]),
        .src_used(src_used[s]),
        .dst     (prod_dst[p]),
        .dst_wen (prod_wen[p]),
        .hit     (hit[s][p])
      );
    end
  end

  hz_fwd_sel u_sel (
    .hit_xm(hit[0][0]),
    .hit_mw(hit[0][1]),
    .sel   (sel_e)
  );
  assign src_a_sel = sel_e;

  hz_stall_gen u_stall (
    .hit_a_ex (hit[0][0]),
    .hit_b_ex (hit[1][0]),
    .hit_b_mem(hit[1][1]),
    .ex_load  (ex_load),
    .stall    (stall)
  );

  hz_regfile_wt #(.NREG(NREG), .DW(DW), .NRD(NSRC)) u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_addr(src_idx),
    .rd_data(rd_data),
    .wr_addr(wb_dst),
    .wr_en  (wb_wen),
    .wr_data(wb_data)
  );
  assign src_a_data = rd_data[0];
  assign src_b_data = rd_data[1];

  // R1: only three select codes exist
  assert_sel_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    src_a_sel != 2'd3);
  // R5: load in execute feeding source A must hold decode
  assert_load_use_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_load && ex_wen && ex_dst != '0 && dec_src_a_used && dec_src_a == ex_dst) |-> stall);
  // R6: source B produced in memory cannot be bypassed
  assert_b_mem_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_src_b_used && dec_src_b != '0 && mem_wen && mem_dst == dec_src_b) |-> stall);
  // R7: zero sources never depend on anything
  assert_zero_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_src_a == '0 && dec_src_b == '0) |-> (!stall && src_a_sel == 2'd0));
  // R10: with B unused and no load in execute, source A is never stalled
  assert_a_no_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_src_b_used && !ex_load) |-> !stall);
endmodule

// File: tb/sim_partial_fwd_hazard_unit.sv
module sim_partial_fwd_hazard_unit;
  localparam int NREG = 8;
  localparam int DW   = 16;
  localparam int AW   = 3;

  typedef struct packed {
    logic [AW-1:0] sa; logic ua; logic [AW-1:0] sb; logic ub;
    logic [AW-1:0] xd; logic xw; logic xl;
    logic [AW-1:0] md; logic mw;
    logic [AW-1:0] wd; logic ww; logic [DW-1:0] wdat;
  } stim_t;

  typedef struct {
    logic [DW-1:0] a; logic [DW-1:0] b; logic [1:0] sel; logic st; string tag;
  } exp_t;

  logic clk = 0, rst_n = 0;
  stim_t cur = '0;
  logic [DW-1:0] src_a_data, src_b_data;
  logic [1:0] src_a_sel;
  logic stall;
  logic [DW-1:0] model [NREG];
  exp_t q[$];
  event chk_ev;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  partial_fwd_hazard_unit #(.NREG(NREG), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .dec_src_a(cur.sa), .dec_src_a_used(cur.ua),
    .dec_src_b(cur.sb), .dec_src_b_used(cur.ub),
    .ex_dst(cur.xd), .ex_wen(cur.xw), .ex_load(cur.xl),
    .mem_dst(cur.md), .mem_wen(cur.mw),
    .wb_dst(cur.wd), .wb_wen(cur.ww), .wb_data(cur.wdat),
    .src_a_data(src_a_data), .src_b_data(src_b_data),
    .src_a_sel(src_a_sel), .stall(stall));

  always @(posedge clk) begin
    if (!rst_n) for (int i = 0; i < NREG; i++) model[i] <= '0;
    else if (cur.ww && cur.wd != 0) model[cur.wd] <= cur.wdat;
  end

  function automatic logic [DW-1:0] rd_exp(logic [AW-1:0] a, stim_t s);
    if (a == 0) return '0;
    if (s.ww && s.wd == a) return s.wdat;   // R8 write-through
    return model[a];
  endfunction

  function automatic bit dep(logic [AW-1:0] src, logic used, logic [AW-1:0] d, logic w);
    return used && w && d != 0 && src == d;
  endfunction

  task automatic step(stim_t s, string tag);
    exp_t e;
    bit a_x, a_m, b_x, b_m, lu;
    @(negedge clk);
    cur = s;
    #1;
    a_x = dep(s.sa, s.ua, s.xd, s.xw); a_m = dep(s.sa, s.ua, s.md, s.mw);
    b_x = dep(s.sb, s.ub, s.xd, s.xw); b_m = dep(s.sb, s.ub, s.md, s.mw);
    lu  = s.xl && (a_x || b_x);
    e.a = rd_exp(s.sa, s); e.b = rd_exp(s.sb, s);
    e.sel = a_x ? 2'd1 : (a_m ? 2'd2 : 2'd0);
    e.st  = lu || b_x || b_m;
    if (tag == "") tag = lu ? "R5" : (e.st ? "R6" : (e.sel == 1 ? "R2" : (e.sel == 2 ? "R3" : "R4")));
    e.tag = tag;
    q.push_back(e);
    -> chk_ev;
  endtask

  task automatic cmp(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(chk_ev);
      #1;
      e = q.pop_front();
      cmp(e.tag, "src_a_data", src_a_data, e.a);
      cmp(e.tag, "src_b_data", src_b_data, e.b);
      cmp(e.tag, "src_a_sel", {14'd0, src_a_sel}, {14'd0, e.sel});
      cmp(e.tag, "stall", {15'd0, stall}, {15'd0, e.st});
    end
  end

  function automatic stim_t mk(int sa, int ua, int sb, int ub, int xd, int xw, int xl,
                               int md, int mw, int wd, int ww, int wdat);
    stim_t s;
    s.sa = AW'(sa); s.ua = ua[0]; s.sb = AW'(sb); s.ub = ub[0];
    s.xd = AW'(xd); s.xw = xw[0]; s.xl = xl[0];
    s.md = AW'(md); s.mw = mw[0]; s.wd = AW'(wd); s.ww = ww[0]; s.wdat = DW'(wdat);
    return s;
  endfunction

  initial begin : driver
    stim_t s;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step(mk(3,1,5,1, 0,0,0, 0,0, 0,0,0), "R9");              // reset values
    step(mk(3,1,1,1, 0,0,0, 0,0, 3,1,16'hAAAA), "R8");       // write-through A
    step(mk(3,1,1,1, 0,0,0, 0,0, 0,0,0), "R9");              // held
    step(mk(2,1,5,1, 0,0,0, 0,0, 5,1,16'h1234), "R8");       // write-through B
    step(mk(0,1,0,1, 0,0,0, 0,0, 0,1,16'hFFFF), "R9");       // r0 write dropped
    step(mk(0,1,0,1, 0,0,0, 0,0, 0,0,0), "R9");
    step(mk(4,1,1,0, 4,1,0, 0,0, 0,0,0), "R2");              // ex forward
    step(mk(4,1,1,0, 4,1,0, 4,1, 0,0,0), "R2");              // ex beats mem
    step(mk(6,1,1,0, 0,0,0, 6,1, 0,0,0), "R3");              // mem forward
    step(mk(6,1,1,0, 2,1,0, 0,0, 6,1,16'h0077), "R4");       // wb only
    step(mk(4,1,1,0, 4,1,1, 0,0, 0,0,0), "R5");              // load-use on A
    step(mk(1,1,7,1, 7,1,1, 0,0, 0,0,0), "R5");              // load-use on B
    step(mk(1,1,7,1, 7,1,0, 0,0, 0,0,0), "R6");              // B in ex
    step(mk(1,1,7,1, 0,0,0, 7,1, 0,0,0), "R6");              // B in mem
    step(mk(1,1,7,1, 0,0,0, 0,0, 7,1,16'h0BBB), "R6");       // B in wb: no stall
    step(mk(4,1,7,1, 4,0,1, 7,0, 0,0,0), "R7");              // wen low
    step(mk(0,1,0,1, 0,1,1, 0,1, 0,0,0), "R7");              // register 0
    step(mk(4,0,7,0, 4,1,1, 7,1, 0,0,0), "R7");              // sources unused
    step(mk(5,1,2,0, 5,1,0, 0,0, 0,0,0), "R10");             // A fwd no stall
    step(mk(5,1,2,0, 0,0,0, 5,1, 0,0,0), "R10");             // load now in mem
    for (int i = 0; i < 400; i++) begin
      s = stim_t'({$urandom, $urandom});
      step(s, "");
    end
    @(negedge clk);
    done = 1;
  end

  initial begin : watchdog
    int cyc = 0;
    while (!done && cyc < 5000) begin @(posedge clk); cyc++; end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    #3;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule